// File: doc/BRIEF.md
# CAN Acceptance Filter and Receive Queue

This block sits behind a CAN protocol engine that has already received a whole frame. The engine presents the frame for one clock with a valid strobe: the identifier, the IDE and RTR bits, the data length code and up to eight data bytes, all in parallel. The block tests the frame against three programmable filters. Each filter has a mask word and a code word. A frame that passes any filter is stored in a four-entry receive queue. The index of the filter that accepted it is stored with the frame. A frame that passes no filter is discarded.

The host sees the block through a small register port. Through it the host programs the filters, selects what happens when the queue is full, reads queue occupancy and two sticky flags, and reads the oldest stored frame as four 32-bit words. Reading the last of those words removes the frame from the queue. The `irq` output is high while either flag is set.

The queue is controlled by an occupancy state machine with three states: `ST_EMPTY`, `ST_PARTIAL` and `ST_FULL`. Its transitions are:

- empty→partial on a store;
- partial→full on a store without a pop when three frames are held;
- partial→empty on a pop without a store when one frame is held;
- full→partial on a pop without a store.

Every other case holds the current state. In each cycle a write action is chosen from `ACT_IDLE`, `ACT_STORE`, `ACT_REPLACE` and `ACT_DROP`.

Top module: `can_acc_rxq`

## Requirements
- R1: After reset the queue is empty, both flags are clear, all filter masks and codes are zero, the overwrite option is off, and `irq` is low.
- R2: Filter words use bits [28:0] for the identifier, bit 29 for IDE and bit 30 for RTR. A filter accepts a frame when every bit set in its mask matches the frame's bit at the same position in the code word. A mask of zero therefore accepts every frame. Filter k has its mask at address 2k and its code at address 2k+1, and both read back as written.
- R3: For a frame with IDE=0, identifier bits 17:0 are neither compared nor stored, and they read back as zero.
- R4: When several filters accept a frame, the lowest index is recorded. A frame that no filter accepts changes no state.
- R5: The queue holds up to four frames and returns them oldest first. Each head entry is read as four words:
  - address 8: the identifier;
  - address 9: DLC in bits [3:0], IDE in bit 4, RTR in bit 5 and the filter index in bits [10:8];
  - address 10: data bits [31:0];
  - address 11: data bits [63:32].
- R6: A read of address 11 removes the head entry. Reading a head word while the queue is empty returns zero and removes nothing.
- R7: The status register at address 7 holds:
  - the fill count modulo four in bits [1:0];
  - a full bit in bit 2;
  - the receive flag in bit 8;
  - the overrun flag in bit 9.
- R8: With the overwrite option (bit 0 of address 6) clear, an accepted frame that arrives while the queue is full and no pop happens is discarded, and the overrun flag sets.
- R9: With the overwrite option set, such a frame replaces the newest entry. The count is unchanged and the overrun flag does not set.
- R10: A pop and an accepted arrival in the same cycle on a full queue both take effect, with no overrun.
- R11: The receive flag sets on every stored or replaced frame. Writing 1 to a flag bit of the status register clears that flag, but a flag event in the same cycle wins. `irq` equals receive flag OR overrun flag.
- R12: Read data appears on `reg_rdata` in the cycle after `reg_rd` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | One-cycle strobe: a complete frame is on the rx_* inputs |
| rx_id | input | 29 | Frame identifier; a standard frame uses bits 28:18 |
| rx_ide | input | 1 | Extended-identifier bit of the frame |
| rx_rtr | input | 1 | Remote-request bit of the frame |
| rx_dlc | input | 4 | Data length code |
| rx_data | input | 64 | Data bytes, byte 0 in bits [7:0] |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe |
| reg_addr | input | 4 | Host register address |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data, registered |
| irq | output | 1 | High while the receive or overrun flag is set |

## Verification
The hardest case to reach is a full queue that sees a frame arrival in the same cycle as a host pop, a flag clear or both. Each of these outcomes depends on how same-cycle events are ordered. The bench fills the queue to exactly four entries through filters that accept the frame. It then asserts the frame strobe in the same cycle as a read of the last head word or a status write, under both settings of the overwrite option. A behavioural queue model in the bench predicts `irq` on every clock and every read word.

// File: rtl/can_acc_pkg.sv
package can_acc_pkg;

    localparam int ID_W    = 29;
    localparam int DLC_W   = 4;
    localparam int AFI_W   = 3;
    localparam int DATA_W  = 64;
    localparam int VEC_W   = ID_W + 2;
    localparam int STD_LSB = 18;
    localparam int IDE_POS = ID_W;
    localparam int RTR_POS = ID_W + 1;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic              ide;
        logic              rtr;
        logic [DLC_W-1:0]  dlc;
        logic [AFI_W-1:0]  afi;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } occ_state_t;

    typedef enum logic [1:0] {
        ACT_IDLE    = 2'd0,
        ACT_STORE   = 2'd1,
        ACT_REPLACE = 2'd2,
        ACT_DROP    = 2'd3
    } wr_action_t;

endpackage

// File: rtl/can_acc_match.sv
module can_acc_match
    import can_acc_pkg::*;
(
    input  logic [VEC_W-1:0] frame_vec,
    input  logic [VEC_W-1:0] mask_q,
    input  logic [VEC_W-1:0] code_q,
    output logic             hit
);
    logic [VEC_W-1:0] care;

    always_comb begin
        care = mask_q;
        if (!frame_vec[IDE_POS]) begin
            care[STD_LSB-1:0] = '0;
        end
        hit = (((frame_vec ^ code_q) & care) == '0);
    end
endmodule

// File: rtl/can_acc_bank.sv
module can_acc_bank
    import can_acc_pkg::*;
#(
    parameter int N_FILT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [AFI_W-1:0]  cfg_idx,
    input  logic              cfg_is_code,
    input  logic [VEC_W-1:0]  cfg_wdata,
    input  logic [VEC_W-1:0]  frame_vec,
    output logic              any_hit,
    output logic [AFI_W-1:0]  hit_idx,
    output logic [VEC_W-1:0]  mask_rd [N_FILT],
    output logic [VEC_W-1:0]  code_rd [N_FILT]
);
    logic [VEC_W-1:0]  mask_q [N_FILT];
    logic [VEC_W-1:0]  code_q [N_FILT];
    logic [N_FILT-1:0] hit_vec;

    for (genvar g = 0; g < N_FILT; g++) begin : g_filt
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_q[g] <= '0;
                code_q[g] <= '0;
            end else if (cfg_we && (cfg_idx == AFI_W'(g))) begin
                if (cfg_is_code) code_q[g] <= cfg_wdata;
                else             mask_q[g] <= cfg_wdata;
            end
        end

        can_acc_match i_match (
            .frame_vec (frame_vec),
            .mask_q    (mask_q[g]),
            .code_q    (code_q[g]),
            .hit       (hit_vec[g])
        );

        assign mask_rd[g] = mask_q[g];
        assign code_rd[g] = code_q[g];
    end

    // lowest index has priority
    always_comb begin
        hit_idx = '0;
        for (int i = N_FILT - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = AFI_W'(i);
        end
        any_hit = |hit_vec;
    end

    // R4: a reported winner is a filter that actually hit
    p_winner_hits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> hit_vec[hit_idx]);
endmodule

// File: rtl/can_acc_fifo.sv
module can_acc_fifo
    import can_acc_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  rx_entry_t       push_data,
    input  logic            ovw_mode,
    input  logic            pop_req,
    output rx_entry_t       head,
    output logic [$clog2(DEPTH):0] count,
    output logic            not_empty,
    output logic            store_evt,
    output logic            drop_evt
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    occ_state_t       state_q, state_d;
    wr_action_t       act;
    logic             pop_ok;
    logic [PTR_W-1:0] rd_ptr, wr_ptr, wr_idx;
    logic [CNT_W-1:0] cnt_q;
    rx_entry_t        mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (push) state_d = ST_PARTIAL;
            end
            ST_PARTIAL: begin
                if (push && !pop_ok && (cnt_q == CNT_W'(DEPTH - 1)))
                    state_d = ST_FULL;
                else if (pop_ok && !push && (cnt_q == CNT_W'(1)))
                    state_d = ST_EMPTY;
            end
            ST_FULL: begin
                if (pop_ok && !push) state_d = ST_PARTIAL;
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    always_comb begin
        pop_ok = pop_req && (state_q != ST_EMPTY);
        act    = ACT_IDLE;
        unique case (state_q)
            ST_EMPTY, ST_PARTIAL: begin
                if (push) act = ACT_STORE;
            end
            ST_FULL: begin
                if (push) begin
                    if (pop_ok)        act = ACT_STORE;
                    else if (ovw_mode) act = ACT_REPLACE;
                    else               act = ACT_DROP;
                end
            end
            default: act = ACT_IDLE;
        endcase
        wr_idx    = (act == ACT_REPLACE) ? (wr_ptr - PTR_W'(1)) : wr_ptr;
        store_evt = (act == ACT_STORE) || (act == ACT_REPLACE);
        drop_evt  = (act == ACT_DROP);
    end

    always_ff @(posedge clk) begin
        if (store_evt) mem[wr_idx] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (pop_ok) rd_ptr <= rd_ptr + PTR_W'(1);
            if (act == ACT_STORE) wr_ptr <= wr_ptr + PTR_W'(1);
            cnt_q <= cnt_q + CNT_W'(act == ACT_STORE) - CNT_W'(pop_ok);
        end
    end

    assign head      = mem[rd_ptr];
    assign count     = cnt_q;
    assign not_empty = (state_q != ST_EMPTY);

    // R5: never more than DEPTH entries
    p_count_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));
    // R7: state register and counter agree about fullness
    p_full_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FULL) == (cnt_q == CNT_W'(DEPTH)));
    // R8: a dropped frame leaves the count unchanged
    p_drop_keeps_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        drop_evt |=> (cnt_q == CNT_W'(DEPTH)));
    // R6: a pop without a store shrinks the queue by one
    p_pop_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_ok && !push) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/can_acc_rxq.sv
module can_acc_rxq
    import can_acc_pkg::*;
#(
    parameter int N_FILT = 3,
    parameter int DEPTH  = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic [28:0] rx_id,
    input  logic        rx_ide,
    input  logic        rx_rtr,
    input  logic [3:0]  rx_dlc,
    input  logic [63:0] rx_data,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam logic [3:0] A_CFG  = 4'd6;
    localparam logic [3:0] A_STAT = 4'd7;
    localparam logic [3:0] A_ID   = 4'd8;
    localparam logic [3:0] A_CTL  = 4'd9;
    localparam logic [3:0] A_DLO  = 4'd10;
    localparam logic [3:0] A_DHI  = 4'd11;
    localparam logic [3:0] A_FLT_END = 4'(2 * N_FILT);

    logic [VEC_W-1:0] frame_vec;
    logic             any_hit;
    logic [AFI_W-1:0] hit_idx;
    logic [VEC_W-1:0] mask_rd [N_FILT];
    logic [VEC_W-1:0] code_rd [N_FILT];
    rx_entry_t        new_ent, head;
    logic [PTR_W:0]   count;
    logic             not_empty, store_evt, drop_evt, pop_req;
    logic             ovw_q, rxf_q, ovr_q, clr_rx, clr_ovr, flt_we;
    logic [AFI_W-1:0] flt_idx;
    logic [31:0]      rd_mux;

    assign frame_vec = {rx_rtr, rx_ide, rx_id};
    assign flt_we    = reg_wr && (reg_addr < A_FLT_END);
    assign flt_idx   = AFI_W'(reg_addr[3:1]);

    can_acc_bank #(.N_FILT(N_FILT)) i_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (flt_we),
        .cfg_idx     (flt_idx),
        .cfg_is_code (reg_addr[0]),
        .cfg_wdata   (reg_wdata[VEC_W-1:0]),
        .frame_vec   (frame_vec),
        .any_hit     (any_hit),
        .hit_idx     (hit_idx),
        .mask_rd     (mask_rd),
        .code_rd     (code_rd)
    );

    always_comb begin
        new_ent.id   = rx_ide ? rx_id : {rx_id[ID_W-1:STD_LSB], {STD_LSB{1'b0}}};
        new_ent.ide  = rx_ide;
        new_ent.rtr  = rx_rtr;
        new_ent.dlc  = rx_dlc;
        new_ent.afi  = hit_idx;
        new_ent.data = rx_data;
    end

    assign pop_req = reg_rd && (reg_addr == A_DHI);

    can_acc_fifo #(.DEPTH(DEPTH)) i_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_valid && any_hit),
        .push_data (new_ent),
        .ovw_mode  (ovw_q),
        .pop_req   (pop_req),
        .head      (head),
        .count     (count),
        .not_empty (not_empty),
        .store_evt (store_evt),
        .drop_evt  (drop_evt)
    );

    assign clr_rx  = reg_wr && (reg_addr == A_STAT) && reg_wdata[8];
    assign clr_ovr = reg_wr && (reg_addr == A_STAT) && reg_wdata[9];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovw_q <= 1'b0;
            rxf_q <= 1'b0;
            ovr_q <= 1'b0;
        end else begin
            if (reg_wr && (reg_addr == A_CFG)) ovw_q <= reg_wdata[0];
            rxf_q <= (rxf_q && !clr_rx)  || store_evt;
            ovr_q <= (ovr_q && !clr_ovr) || drop_evt;
        end
    end

    always_comb begin
        rd_mux = '0;
        if (reg_addr < A_FLT_END) begin
            rd_mux = reg_addr[0] ? 32'(code_rd[flt_idx]) : 32'(mask_rd[flt_idx]);
        end else begin
            case (reg_addr)
                A_CFG:  rd_mux = {31'b0, ovw_q};
                A_STAT: rd_mux = {22'b0, ovr_q, rxf_q, 5'b0, count[PTR_W], 2'(count)};
                A_ID:   rd_mux = not_empty ? 32'(head.id) : '0;
                A_CTL:  rd_mux = not_empty ? {21'b0, head.afi, 2'b0, head.rtr,
                                              head.ide, head.dlc} : '0;
                A_DLO:  rd_mux = not_empty ? head.data[31:0]  : '0;
                A_DHI:  rd_mux = not_empty ? head.data[63:32] : '0;
                default: rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
    end

    assign irq = rxf_q || ovr_q;

    // R8: a discarded frame on a full queue raises the overrun flag
    p_ovr_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        drop_evt |=> ovr_q);
    // R11: a store raises the receive flag even if a clear is written together
    p_rx_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        store_evt |=> rxf_q);
    // R9: with overwrite enabled no frame is ever dropped
    p_no_drop_ovw_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ovw_q |-> !drop_evt);
endmodule

// File: tb/test_can_acc_rxq.sv
`timescale 1ns/1ps
module test_can_acc_rxq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [28:0] rx_id = '0;
    logic        rx_ide = 1'b0, rx_rtr = 1'b0;
    logic [3:0]  rx_dlc = '0;
    logic [63:0] rx_data = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    can_acc_rxq i_can_acc_rxq (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_id(rx_id),
        .rx_ide(rx_ide), .rx_rtr(rx_rtr), .rx_dlc(rx_dlc), .rx_data(rx_data),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    typedef struct { bit [31:0] w [4]; } ent_t;
    ent_t       q[$];
    bit [30:0]  m_mask [3];
    bit [30:0]  m_code [3];
    bit         m_ovw, m_rxf, m_ovr;
    bit         rd_pend;
    bit [31:0]  exp_rd;

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            for (int k = 0; k < 3; k++) begin m_mask[k] = '0; m_code[k] = '0; end
            m_ovw = 0; m_rxf = 0; m_ovr = 0; rd_pend = 0;
        end else begin
            bit hit; int win; bit [30:0] v; bit [30:0] care; ent_t e;
            rd_pend = reg_rd;
            if (reg_rd) begin
                exp_rd = 0;
                if (reg_addr < 6)
                    exp_rd = reg_addr[0] ? m_code[reg_addr/2] : m_mask[reg_addr/2];
                else if (reg_addr == 6) exp_rd = m_ovw;
                else if (reg_addr == 7)
                    exp_rd = (m_ovr << 9) | (m_rxf << 8) | ((q.size() == 4) << 2) | (q.size() % 4);
                else if (reg_addr <= 11 && q.size() > 0) exp_rd = q[0].w[reg_addr - 8];
                if (reg_addr == 11 && q.size() > 0) void'(q.pop_front());
            end
            hit = 0; win = 0;
            if (rx_valid) begin
                v = {rx_rtr, rx_ide, rx_id};
                for (int k = 2; k >= 0; k--) begin
                    care = m_mask[k];
                    if (!rx_ide) care[17:0] = '0;
                    if (((v ^ m_code[k]) & care) == 0) begin hit = 1; win = k; end
                end
            end
            if (reg_wr) begin
                if (reg_addr < 6) begin
                    if (reg_addr[0]) m_code[reg_addr/2] = reg_wdata[30:0];
                    else             m_mask[reg_addr/2] = reg_wdata[30:0];
                end else if (reg_addr == 6) m_ovw = reg_wdata[0];
                else if (reg_addr == 7) begin
                    if (reg_wdata[8]) m_rxf = 0;
                    if (reg_wdata[9]) m_ovr = 0;
                end
            end
            if (hit) begin
                e.w[0] = rx_ide ? {3'b0, rx_id} : {3'b0, rx_id[28:18], 18'b0};
                e.w[1] = (win << 8) | (rx_rtr << 5) | (rx_ide << 4) | rx_dlc;
                e.w[2] = rx_data[31:0];
                e.w[3] = rx_data[63:32];
                if (q.size() < 4) begin q.push_back(e); m_rxf = 1; end
                else if (m_ovw) begin q[3] = e; m_rxf = 1; end
                else m_ovr = 1;
            end
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (irq !== (m_rxf | m_ovr)) begin
                fails++;
                $display("FAIL R11 irq act=%0b exp=%0b", irq, m_rxf | m_ovr);
            end
            if (rd_pend) begin
                checks++;
                if (reg_rdata !== exp_rd) begin
                    fails++;
                    $display("FAIL R12 rdata addr=%0d act=%h exp=%h", reg_addr, reg_rdata, exp_rd);
                end
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_rd = 1; reg_addr = a;
        @(negedge clk);
        reg_rd = 0;
        d = reg_rdata;
    endtask

    task automatic set_frame(input logic [28:0] id, input logic ide, input logic rtr,
                             input logic [3:0] dlc, input logic [63:0] data);
        rx_valid = 1; rx_id = id; rx_ide = ide; rx_rtr = rtr; rx_dlc = dlc; rx_data = data;
    endtask

    task automatic frame(input logic [28:0] id, input logic ide, input logic rtr,
                         input logic [3:0] dlc, input logic [63:0] data);
        set_frame(id, ide, rtr, dlc, data);
        @(negedge clk);
        rx_valid = 0;
    endtask

    task automatic drain();
        logic [31:0] d;
        for (int n = 0; n < 6; n++)
            for (int a = 8; a < 12; a++) rd(4'(a), d);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", {31'b0, irq}, 0);
        rd(7, d); chk("R1 status", d, 32'h0);
        rd(0, d); chk("R1 mask0", d, 32'h0);
        rd(6, d); chk("R1 cfg", d, 32'h0);

        // R3 standard frame through all-accepting filters
        frame(29'h1FFFFFFF, 0, 0, 4'd8, 64'h01234567_89ABCDEF);
        rd(7, d);  chk("R7 status one", d, 32'h101);
        rd(8, d);  chk("R3 std id", d, 32'h1FFC0000);
        rd(9, d);  chk("R5 ctl", d, 32'h8);
        rd(10, d); chk("R5 data lo", d, 32'h89ABCDEF);
        rd(11, d); chk("R5 data hi", d, 32'h01234567);
        rd(7, d);  chk("R6 popped", d, 32'h100);
        wr(7, 32'h100);
        rd(7, d);  chk("R11 w1c", d, 32'h0);

        // R6 read of empty queue
        rd(10, d); chk("R6 empty read", d, 32'h0);
        rd(11, d); chk("R6 empty pop", d, 32'h0);
        rd(7, d);  chk("R6 still empty", d, 32'h0);

        // R2 program filters
        wr(0, 32'h7FFFFFFF); wr(1, 32'h20000055);   // ext id 0x55, data frame
        wr(2, 32'h20000000); wr(3, 32'h20000000);   // any extended
        wr(4, 32'h7FFFFFFF); wr(5, 32'h52340000);   // std remote id 0x12340000
        rd(0, d); chk("R2 mask readback", d, 32'h7FFFFFFF);
        rd(5, d); chk("R2 code readback", d, 32'h52340000);

        frame(29'h55, 1, 0, 4'd1, 64'hA);          // filters 0,1 -> 0
        frame(29'h56, 1, 0, 4'd1, 64'hB);          // filter 1
        frame(29'h1234ABCD, 0, 1, 4'd2, 64'hC);    // filter 2
        frame(29'h0, 0, 0, 4'd3, 64'hD);           // no filter
        rd(7, d); chk("R4 no match ignored", d, 32'h103);
        frame(29'h55, 1, 1, 4'd0, 64'hE);          // filter 1
        rd(7, d); chk("R7 full", d, 32'h104);
        frame(29'h77, 1, 0, 4'd4, 64'hF);          // dropped
        rd(7, d); chk("R8 overrun", d, 32'h304);
        rd(9, d); chk("R4 afi0", d, 32'h011);
        rd(11, d);
        rd(9, d); chk("R4 afi1", d, 32'h111);
        rd(11, d);
        rd(8, d); chk("R3 std stored", d, 32'h12340000);
        rd(9, d); chk("R4 afi2", d, 32'h222);
        rd(11, d);
        rd(9, d); chk("R2 rtr mask", d, 32'h130);
        rd(10, d); chk("R8 kept oldest", d, 32'hE);
        rd(11, d);
        wr(7, 32'h300);
        rd(7, d); chk("R11 clear both", d, 32'h0);

        // R10 pop and arrival together on a full queue
        for (int n = 0; n < 4; n++) frame(29'h55, 1, 0, 4'd1, 64'(n));
        wr(7, 32'h100);
        set_frame(29'h56, 1, 0, 4'd7, 64'h77);
        reg_rd = 1; reg_addr = 11;
        @(negedge clk);
        reg_rd = 0; rx_valid = 0;
        rd(7, d); chk("R10 pop+push", d, 32'h104);
        drain();
        wr(7, 32'h300);

        // R9 overwrite newest
        wr(6, 32'h1);
        for (int n = 0; n < 4; n++) frame(29'h55, 1, 0, 4'd1, 64'(n + 16));
        frame(29'h56, 1, 0, 4'd5, 64'h99);
        rd(7, d); chk("R9 no overrun", d, 32'h104);
        for (int n = 0; n < 3; n++) begin rd(10, d); rd(11, d); end
        rd(10, d); chk("R9 replaced", d, 32'h99);
        rd(9, d);  chk("R9 afi", d, 32'h115);
        rd(11, d);
        wr(6, 32'h0);
        wr(7, 32'h300);

        // R11 set wins over a same-cycle clear
        set_frame(29'h55, 1, 0, 4'd2, 64'h5);
        reg_wr = 1; reg_addr = 7; reg_wdata = 32'h100;
        @(negedge clk);
        reg_wr = 0; rx_valid = 0;
        rd(7, d); chk("R11 set wins", d, 32'h101);
        drain();

        repeat (3) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule